// File: doc/BRIEF.md
# Reloadable 24-bit Transfer Counter

This unit holds the byte count for a byte-wide, register-mapped transfer controller. The host writes a start count one byte at a time into three write-side registers. A separate live counter is loaded from that start count when the host issues a command with the DMA flag set. The live counter then counts down as the data path reports moved bytes, and it is cleared when the data path signals that a transfer phase has ended.

The live count can be read back one byte at a time. A count-zero flag is driven as a pin and also appears in a status byte. Until the host first writes the high count byte, reads of that byte return a fixed identifier, which lets driver code probe for the part. The data mover itself lies outside this block. It only supplies a decrement strobe with a byte amount and a completion pulse.

Top module: `xfer_count_unit`

## Requirements
- R1: Write address 0, 1 and 2 select the start count's low, mid and high byte, and write address 3 is the command register, with bit 7 as the DMA flag. Read address 0, 1 and 2 return the live count's low, mid and high byte. Read address 3 returns a status byte: bit 4 is the count-zero flag, bit 0 is the DMA mode, and all other bits are 0.
- R2: Writing a start-count byte never changes the live count.
- R3: A command write with the DMA flag set loads the live count from the start count. A start count of zero loads 0x010000 instead. The command also sets DMA mode.
- R4: A command write with the DMA flag clear clears DMA mode and leaves the live count unchanged.
- R5: A write to any of the three start-count bytes clears the count-zero flag.
- R6: A read of address 2 returns the parameter CHIP_ID until address 2 has been written at least once. After that it returns the live high byte. Reset restores the identifier behaviour.
- R7: A decrement subtracts the amount from the live count and saturates at zero without wrapping.
- R8: The count-zero flag is set in the cycle in which a decrement brings the live count to zero. A reload leaves the flag unchanged.
- R9: A completion pulse forces the live count to zero and sets the count-zero flag.
- R10: In the same cycle, a reload wins over a decrement and over a completion pulse. Setting the count-zero flag wins over clearing it.
- R11: After reset the live count, the start count, the count-zero flag and DMA mode are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| dec_en_i | input | 1 | Decrement strobe from the data path |
| dec_amt_i | input | 8 | Bytes moved in this cycle |
| done_i | input | 1 | Transfer phase completion pulse |
| tc_zero_o | output | 1 | Count-zero flag |

## Verification
Decrements are tried in four patterns:
- an amount equal to the low byte, which checks that no borrow is taken;
- an amount of one across a byte boundary, which checks borrow propagation;
- an amount larger than the count, which checks saturation instead of wrap;
- an amount exactly equal to the count, which checks that the zero flag fires on an exact hit.

Reloads are tried from a nonzero start count and from an all-zero start count. The zero-start case tells the special 0x010000 load apart from a plain copy. Command writes with and without the DMA flag separate a reload from a mode change alone.

Collisions in the same cycle check both priorities:
- a reload with a decrement;
- a count-byte write with a decrement that reaches zero.

Reads of the high byte before and after its first write, and again after reset, separate the identifier from the live byte.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  localparam int unsigned DMA_FLAG_BIT  = 7;
  localparam int unsigned STAT_ZERO_BIT = 4;
  localparam int unsigned STAT_DMA_BIT  = 0;
endpackage

// File: rtl/tcnt_start_regs.sv
module tcnt_start_regs #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  parameter int NB     = 3,
  parameter int AW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  start_o,
  output logic              cnt_wr_o,
  output logic              hi_written_o
);
  localparam int HI_IDX = NB - 1;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              b_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))  b_q <= wr_data_i;
    end
    assign start_o[i*BYTE_W +: BYTE_W] = b_q;
  end

  logic hi_written_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   hi_written_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == AW'(HI_IDX))  hi_written_q <= 1'b1;
  end

  assign hi_written_o = hi_written_q;
  assign cnt_wr_o     = wr_en_i && (wr_addr_i < AW'(NB));

  // R6: once the high byte is written, the identifier stays hidden until reset
  p_hi_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_written_q |=> hi_written_q);
endmodule

// File: rtl/tcnt_live.sv
module tcnt_live #(
  parameter int               CNT_W     = 24,
  parameter int               DEC_W     = 8,
  parameter logic [CNT_W-1:0] ZERO_LOAD = 'h10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             done_i,
  input  logic             dec_en_i,
  input  logic [DEC_W-1:0] dec_amt_i,
  output logic [CNT_W-1:0] live_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] live_q, live_d, dec_next, load_val, amt_ext;

  always_comb begin
    amt_ext  = CNT_W'(dec_amt_i);
    dec_next = (live_q > amt_ext) ? live_q - amt_ext : '0;
    load_val = (start_i == '0) ? ZERO_LOAD : start_i;
    if (reload_i)      live_d = load_val;
    else if (done_i)   live_d = '0;
    else if (dec_en_i) live_d = dec_next;
    else               live_d = live_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else         live_q <= live_d;
  end

  assign live_o     = live_q;
  assign zero_evt_o = !reload_i && (done_i || (dec_en_i && dec_next == '0));

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> live_q == (($past(start_i) == '0) ? ZERO_LOAD : $past(start_i)));
  p_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && !reload_i && !done_i) |=> live_q <= $past(live_q));
  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !reload_i) |=> live_q == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !done_i && !dec_en_i) |=> $stable(live_q));
endmodule

// File: rtl/tcnt_status.sv
module tcnt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic cmd_wr_i,
  input  logic dma_flag_i,
  output logic zero_o,
  output logic dma_mode_o
);
  logic zero_q, dma_q;

  // set beats clear so a completion is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    zero_q <= 1'b0;
    else if (set_i) zero_q <= 1'b1;
    else if (clr_i) zero_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dma_q <= 1'b0;
    else if (cmd_wr_i) dma_q <= dma_flag_i;
  end

  assign zero_o     = zero_q;
  assign dma_mode_o = dma_q;

  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> zero_q);
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !zero_q);
  p_dma_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !dma_flag_i) |=> !dma_q);
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int                CNT_W     = 24,
  parameter int                BYTE_W    = 8,
  parameter int                DEC_W     = 8,
  parameter logic [CNT_W-1:0]  ZERO_LOAD = 'h10000,
  parameter logic [BYTE_W-1:0] CHIP_ID   = 8'h5C,
  localparam int               NB        = CNT_W / BYTE_W,
  localparam int               AW        = $clog2(NB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              dec_en_i,
  input  logic [DEC_W-1:0]  dec_amt_i,
  input  logic              done_i,
  output logic              tc_zero_o
);
  import tcnt_pkg::*;

  logic [CNT_W-1:0] start_cnt, live_cnt;
  logic cnt_wr, hi_written, zero_evt, dma_mode, zero_flag;
  logic cmd_wr, dma_flag, reload;

  assign cmd_wr   = wr_en_i && (wr_addr_i == AW'(NB));
  assign dma_flag = wr_data_i[DMA_FLAG_BIT];
  assign reload   = cmd_wr && dma_flag;

  tcnt_start_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .NB(NB), .AW(AW)) u_start (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .start_o      (start_cnt),
    .cnt_wr_o     (cnt_wr),
    .hi_written_o (hi_written)
  );

  tcnt_live #(.CNT_W(CNT_W), .DEC_W(DEC_W), .ZERO_LOAD(ZERO_LOAD)) u_live (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload),
    .start_i    (start_cnt),
    .done_i     (done_i),
    .dec_en_i   (dec_en_i),
    .dec_amt_i  (dec_amt_i),
    .live_o     (live_cnt),
    .zero_evt_o (zero_evt)
  );

  tcnt_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (zero_evt),
    .clr_i      (cnt_wr),
    .cmd_wr_i   (cmd_wr),
    .dma_flag_i (dma_flag),
    .zero_o     (zero_flag),
    .dma_mode_o (dma_mode)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(NB)) begin
      rd_data_o[STAT_ZERO_BIT] = zero_flag;
      rd_data_o[STAT_DMA_BIT]  = dma_mode;
    end else begin
      for (int i = 0; i < NB; i++)
        if (rd_addr_i == AW'(i)) rd_data_o = live_cnt[i*BYTE_W +: BYTE_W];
      if (rd_addr_i == AW'(NB - 1) && !hi_written) rd_data_o = CHIP_ID;
    end
  end

  assign tc_zero_o = zero_flag;

  // R2: a count-byte write alone never moves the live count
  p_wr_no_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && !dec_en_i && !done_i) |=> $stable(live_cnt));
endmodule

// File: tb/xfer_count_unit_test.sv
`timescale 1ns/1ps
module xfer_count_unit_test;
  localparam logic [7:0] ID = 8'h5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic dec_en = 1'b0;
  logic [7:0] dec_amt = '0;
  logic done = 1'b0;
  logic tc_zero;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xfer_count_unit #(.CHIP_ID(ID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dec_en_i(dec_en), .dec_amt_i(dec_amt), .done_i(done), .tc_zero_o(tc_zero)
  );

  // {req[27:24], op[23:21], waddr[20:19], wdata[18:11], raddr[10:9], exp_rd[8:1], exp_zero[0]}
  // op: 0 idle, 1 write, 2 decrement by wdata, 3 completion,
  //     4 write + decrement by 2, 5 write + decrement by 3
  localparam int NV = 35;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2,  3'd1, 2'd0, 8'h34, 2'd0, 8'h00, 1'b0}, // R2
    {4'd2,  3'd1, 2'd1, 8'h12, 2'd1, 8'h00, 1'b0}, // R2
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd0, 8'h34, 1'b0}, // R3
    {4'd1,  3'd0, 2'd0, 8'h00, 2'd1, 8'h12, 1'b0}, // R1
    {4'd6,  3'd0, 2'd0, 8'h00, 2'd2, ID,    1'b0}, // R6 identifier before first high write
    {4'd7,  3'd2, 2'd0, 8'h34, 2'd0, 8'h00, 1'b0}, // R7
    {4'd7,  3'd2, 2'd0, 8'h01, 2'd0, 8'hFF, 1'b0}, // R7 borrow
    {4'd7,  3'd0, 2'd0, 8'h00, 2'd1, 8'h11, 1'b0}, // R7
    {4'd7,  3'd2, 2'd0, 8'hFF, 2'd0, 8'h00, 1'b0}, // R7
    {4'd2,  3'd1, 2'd0, 8'h05, 2'd0, 8'h00, 1'b0}, // R2
    {4'd4,  3'd1, 2'd3, 8'h00, 2'd3, 8'h00, 1'b0}, // R4 mode off
    {4'd4,  3'd0, 2'd0, 8'h00, 2'd1, 8'h11, 1'b0}, // R4 no reload
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd0, 8'h05, 1'b0}, // R3
    {4'd6,  3'd1, 2'd2, 8'h01, 2'd2, 8'h00, 1'b0}, // R6 live byte after write
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd2, 8'h01, 1'b0}, // R3
    {4'd2,  3'd1, 2'd0, 8'h00, 2'd0, 8'h05, 1'b0}, // R2
    {4'd2,  3'd1, 2'd1, 8'h00, 2'd1, 8'h12, 1'b0}, // R2
    {4'd2,  3'd1, 2'd2, 8'h00, 2'd2, 8'h01, 1'b0}, // R2
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd2, 8'h01, 1'b0}, // R3 zero start loads 0x010000
    {4'd3,  3'd0, 2'd0, 8'h00, 2'd1, 8'h00, 1'b0}, // R3
    {4'd7,  3'd2, 2'd0, 8'hFF, 2'd0, 8'h01, 1'b0}, // R7
    {4'd2,  3'd1, 2'd0, 8'h03, 2'd1, 8'hFF, 1'b0}, // R2
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd0, 8'h03, 1'b0}, // R3
    {4'd8,  3'd2, 2'd0, 8'h10, 2'd3, 8'h11, 1'b1}, // R8 saturating hit
    {4'd7,  3'd2, 2'd0, 8'h05, 2'd0, 8'h00, 1'b1}, // R7 stays at zero
    {4'd5,  3'd1, 2'd1, 8'h00, 2'd3, 8'h01, 1'b0}, // R5
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd0, 8'h03, 1'b0}, // R3
    {4'd9,  3'd3, 2'd0, 8'h00, 2'd0, 8'h00, 1'b1}, // R9
    {4'd8,  3'd1, 2'd3, 8'h80, 2'd0, 8'h03, 1'b1}, // R8 reload keeps flag
    {4'd5,  3'd1, 2'd1, 8'h00, 2'd3, 8'h01, 1'b0}, // R5
    {4'd10, 3'd4, 2'd3, 8'h80, 2'd0, 8'h03, 1'b0}, // R10 reload beats decrement
    {4'd10, 3'd5, 2'd0, 8'h07, 2'd0, 8'h00, 1'b1}, // R10 set beats clear
    {4'd3,  3'd1, 2'd3, 8'h80, 2'd0, 8'h07, 1'b1}, // R3
    {4'd8,  3'd2, 2'd0, 8'h07, 2'd0, 8'h00, 1'b1}, // R8 exact hit
    {4'd5,  3'd1, 2'd0, 8'h09, 2'd3, 8'h01, 1'b0}  // R5
  };

  task automatic check(input int req, input int idx, input logic [7:0] exp_rd,
                       input logic exp_z);
    total++;
    if (rd_data !== exp_rd || tc_zero !== exp_z) begin
      bad++;
      $display("FAIL R%0d step %0d: rd=%h exp=%h zero=%b exp=%b",
               req, idx, rd_data, exp_rd, tc_zero, exp_z);
    end
  endtask

  task automatic run_vec(input int idx, input logic [27:0] v);
    logic [2:0] op;
    op = v[23:21];
    @(negedge clk);
    rd_addr = v[10:9];
    wr_en   = (op == 3'd1) || (op == 3'd4) || (op == 3'd5);
    wr_addr = v[20:19];
    wr_data = v[18:11];
    dec_en  = (op == 3'd2) || (op == 3'd4) || (op == 3'd5);
    dec_amt = (op == 3'd4) ? 8'd2 : (op == 3'd5) ? 8'd3 : v[18:11];
    done    = (op == 3'd3);
    @(posedge clk);
    #1;
    wr_en = 1'b0; dec_en = 1'b0; done = 1'b0;
    #1;
    check(int'(v[27:24]), idx, v[8:1], v[0]);
  endtask

  task automatic read_chk(input int idx, input logic [1:0] a, input logic [7:0] exp_rd,
                          input logic exp_z);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(11, idx, exp_rd, exp_z);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    read_chk(100, 2'd0, 8'h00, 1'b0);
    read_chk(101, 2'd3, 8'h00, 1'b0);
    read_chk(102, 2'd2, ID, 1'b0);
    for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);
    // R6 live high byte after write, then reset restores identifier
    read_chk(200, 2'd2, 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk(201, 2'd2, ID, 1'b0);    // R6
    read_chk(202, 2'd0, 8'h00, 1'b0); // R11
    read_chk(203, 2'd3, 8'h00, 1'b0); // R11
    // R11 start count cleared: zero start reloads 0x010000
    run_vec(204, {4'd11, 3'd1, 2'd3, 8'h80, 2'd1, 8'h00, 1'b0});
    run_vec(205, {4'd11, 3'd1, 2'd2, 8'h00, 2'd2, 8'h01, 1'b0});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule